// File: doc/BRIEF.md
# Byte-Banked 16-bit Memory with Even/Odd Lanes

This block is a read/write memory on a 16-bit data bus, built from two byte-wide banks. One bank stores the bytes at even addresses and uses the low data lane, bits 7..0. The other bank stores the bytes at odd addresses and uses the high lane, bits 15..8. The master picks the banks with address bit 0 for the low bank and with an active-low high-byte enable for the high bank. With these two signals it can make a byte transfer on either lane, or a word transfer when the word is aligned to an even address.

An upstream region decoder compares the upper address bits and drives `sel_i`. For example, a match on the top three bits of a 20-bit address places the pair over a 128 KiB window. Both banks use the same row address, taken from the address bits just above bit 0. A word that starts at an odd address has to be split by the master into two cycles. The first cycle moves the odd byte on the high lane. The second cycle moves the even byte of the next word on the low lane.

A write lands on the rising clock edge where the write strobe is low, the select is high and reset is released. Read data is combinational from the array while the read strobe is low and the select is high. The block decodes each cycle into one of four kinds: NONE, EVEN, ODD or WORD. There is no sequential control state.

Top module: `banked_mem16`

## Requirements
- R1: With address bit 0 = 0 and `bhe_n_i` = 1, the cycle reaches only the even bank. A write stores `wdata_i[7:0]` at that row's even byte, and the odd byte stays unchanged.
- R2: With address bit 0 = 1 and `bhe_n_i` = 0, the cycle reaches only the odd bank. A write stores `wdata_i[15:8]` at that row's odd byte, and a read returns that byte on `rdata_o[15:8]`.
- R3: With address bit 0 = 0 and `bhe_n_i` = 0, a word cycle writes or reads both bytes of the row together: low byte on bits 7..0, high byte on bits 15..8.
- R4: With address bit 0 = 1 and `bhe_n_i` = 1, no bank is selected. A write changes nothing, and a read returns 0.
- R5: On a byte read, the half of `rdata_o` that belongs to the unselected bank is 0.
- R6: A write takes effect only on a rising edge where `wr_n_i` = 0, `sel_i` = 1 and `rst_n` = 1. A write strobe with `sel_i` = 0 or during reset leaves the array unchanged.
- R7: `rdata_o` shows the array contents in the same cycle while `rd_n_i` = 0 and `sel_i` = 1. Otherwise it is 0.
- R8: The row is `addr_i[ROW_W:1]`. Address bits above ROW_W are not decoded here, so addresses that differ only in those bits reach the same row.
- R9: A word at an odd address X, moved as the odd byte at X followed by the even byte at X+1, reads back intact through the same two-cycle split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| addr_i | input | 20 | Byte address; bit 0 enables the even bank |
| bhe_n_i | input | 1 | Active-low enable for the odd (high) bank |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| sel_i | input | 1 | Region select from the external decoder |
| wdata_i | input | 16 | Write data, even byte on 7..0, odd byte on 15..8 |
| rdata_o | output | 16 | Read data, zero on an unselected lane |

## Verification
A wrong lane decode corrupts one byte of the row. The damage shows up on the first read of that row, usually as a byte on the wrong lane or a neighbouring byte that was overwritten. A wrong row slice shows up as aliasing between rows that should be distinct. A missing write gate does not show at the moment of the bad write. It shows on the next read of the affected byte, which the byte-array reference model flags. Leaks onto an unselected lane and read data outside a read cycle show up in the same cycle on `rdata_o`.

// File: rtl/banked_mem16_pkg.sv
package banked_mem16_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_EVEN = 2'd1,
        XFER_ODD  = 2'd2,
        XFER_WORD = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/bank_steer.sv
module bank_steer
    import banked_mem16_pkg::*;
(
    input  logic             a0_i,
    input  logic             bhe_n_i,
    input  logic             rd_n_i,
    input  logic             wr_n_i,
    input  logic             sel_i,
    input  logic             rst_n,
    output logic [LANES-1:0] we_o,
    output logic [LANES-1:0] re_o
);

    xfer_kind_e     kind;
    logic [LANES-1:0] lane_en;

    always_comb begin
        kind = xfer_kind_e'({~bhe_n_i, ~a0_i});
    end

    always_comb begin
        unique case (kind)
            XFER_NONE: lane_en = 2'b00;
            XFER_EVEN: lane_en = 2'b01;
            XFER_ODD:  lane_en = 2'b10;
            XFER_WORD: lane_en = 2'b11;
            default:   lane_en = 2'b00;
        endcase
    end

    always_comb begin
        we_o = (sel_i && !wr_n_i && rst_n) ? lane_en : '0;
        re_o = (sel_i && !rd_n_i) ? lane_en : '0;
    end

    // R3: both lanes only for an aligned word
    always_comb begin
        if (sel_i && (we_o == 2'b11 || re_o == 2'b11)) begin
            assert_word_aligned_R3: assert (!a0_i && !bhe_n_i);
        end
    end

endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
    parameter int ROW_W = 10,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [W-1:0]     wr_data_i,
    output logic [W-1:0]     rd_data_o
);

    localparam int DEPTH = 1 << ROW_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[row_i] <= wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = mem[row_i];
    end

    // R6: a written byte is visible at the same row on the next cycle
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i ##1 $stable(row_i) |-> rd_data_o == $past(wr_data_i));

    // R6: with no write, a held row keeps its content
    assert_no_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i ##1 $stable(row_i) |-> $stable(rd_data_o));

endmodule

// File: rtl/banked_mem16.sv
module banked_mem16
    import banked_mem16_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int ROW_W  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   bhe_n_i,
    input  logic                   rd_n_i,
    input  logic                   wr_n_i,
    input  logic                   sel_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DATA_W = LANES * LANE_W;

    logic [LANES-1:0] we;
    logic [LANES-1:0] re;
    logic [ROW_W-1:0] row;
    logic [LANE_W-1:0] bank_rd [LANES];
    logic unused_hi_addr;

    assign row            = addr_i[ROW_W:1];
    assign unused_hi_addr = ^addr_i[ADDR_W-1:ROW_W+1];

    bank_steer u_steer (
        .a0_i    (addr_i[0]),
        .bhe_n_i (bhe_n_i),
        .rd_n_i  (rd_n_i),
        .wr_n_i  (wr_n_i),
        .sel_i   (sel_i),
        .rst_n   (rst_n),
        .we_o    (we),
        .re_o    (re)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_bank #(
            .ROW_W (ROW_W),
            .W     (LANE_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_i      (we[g]),
            .row_i     (row),
            .wr_data_i (wdata_i[g*LANE_W +: LANE_W]),
            .rd_data_o (bank_rd[g])
        );

        always_comb begin
            rdata_o[g*LANE_W +: LANE_W] = re[g] ? bank_rd[g] : '0;
        end
    end

    // R7: no read cycle, quiet bus
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n_i || !sel_i) |-> rdata_o == '0);

    // R4: neither bank selected
    assert_no_bank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !rd_n_i && addr_i[0] && bhe_n_i) |-> rdata_o == '0);

    // R5: even-only read leaves the high lane at zero
    assert_even_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !rd_n_i && !addr_i[0] && bhe_n_i) |-> rdata_o[DATA_W-1:LANE_W] == '0);

    // R5: odd-only read leaves the low lane at zero
    assert_odd_lo_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !rd_n_i && addr_i[0] && !bhe_n_i) |-> rdata_o[LANE_W-1:0] == '0);

endmodule

// File: tb/banked_mem16_tb.sv
module banked_mem16_tb;

    localparam int ADDR_W = 20;
    localparam int ROW_W  = 10;
    localparam int NBYTE  = 1 << (ROW_W + 1);

    logic        clk = 0;
    logic        rst_n = 0;
    logic [19:0] addr = '0;
    logic        bhe_n = 1;
    logic        rd_n = 1;
    logic        wr_n = 1;
    logic        sel = 0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    logic [7:0] model [NBYTE];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    banked_mem16 #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .bhe_n_i(bhe_n),
        .rd_n_i(rd_n), .wr_n_i(wr_n), .sel_i(sel), .wdata_i(wdata),
        .rdata_o(rdata)
    );

    function automatic int base_idx(logic [19:0] a);
        return int'({a[ROW_W:1], 1'b0});
    endfunction

    function automatic logic [15:0] exp_read(logic [19:0] a, logic bn);
        logic [15:0] v;
        v = '0;
        if (!a[0]) v[7:0]  = model[base_idx(a)];
        if (!bn)   v[15:8] = model[base_idx(a) + 1];
        return v;
    endfunction

    task automatic model_write(logic [19:0] a, logic bn, logic [15:0] d);
        if (!a[0]) model[base_idx(a)]     = d[7:0];
        if (!bn)   model[base_idx(a) + 1] = d[15:8];
    endtask

    task automatic check16(logic [15:0] act, logic [15:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [19:0] a, logic bn, logic [15:0] d, logic s);
        @(negedge clk);
        addr = a; bhe_n = bn; wdata = d; sel = s; wr_n = 0; rd_n = 1;
        @(posedge clk);
        #1;
        wr_n = 1; sel = 0;
    endtask

    task automatic bus_read(logic [19:0] a, logic bn, output logic [15:0] d);
        @(negedge clk);
        addr = a; bhe_n = bn; sel = 1; rd_n = 0; wr_n = 1;
        #2;
        d = rdata;
        @(posedge clk);
        #1;
        rd_n = 1; sel = 0;
    endtask

    // misaligned word split by the test master (R9)
    task automatic split_write(logic [19:0] a, logic [15:0] w);
        bus_write(a, 1'b0, {w[7:0], 8'h00}, 1'b1);
        model_write(a, 1'b0, {w[7:0], 8'h00});
        bus_write(a + 20'd1, 1'b1, {8'h00, w[15:8]}, 1'b1);
        model_write(a + 20'd1, 1'b1, {8'h00, w[15:8]});
    endtask

    task automatic split_read(logic [19:0] a, output logic [15:0] w);
        logic [15:0] p0, p1;
        bus_read(a, 1'b0, p0);
        bus_read(a + 20'd1, 1'b1, p1);
        w = {p1[7:0], p0[15:8]};
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] r;
        logic [19:0] a;
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        #1;
        check16(rdata, 16'h0000, "R7 idle during reset");
        rst_n = 1;

        // fill array with known words
        for (int i = 0; i < NBYTE / 2; i++) begin
            bus_write(20'(2 * i), 1'b0, 16'(i * 16'h0101 + 16'h3C00), 1'b1);
            model_write(20'(2 * i), 1'b0, 16'(i * 16'h0101 + 16'h3C00));
        end

        // R3 word
        bus_write(20'h00010, 1'b0, 16'hBEEF, 1'b1); model_write(20'h00010, 1'b0, 16'hBEEF);
        bus_read(20'h00010, 1'b0, r); check16(r, 16'hBEEF, "R3 word read");

        // R1 even byte write leaves odd byte
        bus_write(20'h00010, 1'b1, 16'h7711, 1'b1); model_write(20'h00010, 1'b1, 16'h7711);
        bus_read(20'h00010, 1'b0, r); check16(r, 16'hBE11, "R1 even byte write");

        // R2 odd byte write and read
        bus_write(20'h00011, 1'b0, 16'h5A99, 1'b1); model_write(20'h00011, 1'b0, 16'h5A99);
        bus_read(20'h00011, 1'b0, r); check16(r, 16'h5A00, "R2 odd byte read");

        // R5 even byte read, high half zero
        bus_read(20'h00010, 1'b1, r); check16(r, 16'h0011, "R5 even read high zero");

        // R4 no bank: write ignored, read zero
        bus_write(20'h00011, 1'b1, 16'hFFFF, 1'b1);
        bus_read(20'h00011, 1'b1, r); check16(r, 16'h0000, "R4 no-bank read");
        bus_read(20'h00010, 1'b0, r); check16(r, 16'h5A11, "R4 no-bank write ignored");

        // R6 write without select ignored
        bus_write(20'h00020, 1'b0, 16'h1234, 1'b0);
        bus_read(20'h00020, 1'b0, r); check16(r, exp_read(20'h00020, 1'b0), "R6 unselected write");

        // R6 write during reset ignored
        @(negedge clk); rst_n = 0;
        bus_write(20'h00020, 1'b0, 16'hCAFE, 1'b1);
        @(negedge clk); rst_n = 1;
        bus_read(20'h00020, 1'b0, r); check16(r, exp_read(20'h00020, 1'b0), "R6 write in reset");

        // R7 select low during read strobe gives zero
        @(negedge clk); addr = 20'h00010; bhe_n = 0; rd_n = 0; sel = 0;
        #2; check16(rdata, 16'h0000, "R7 read without select");
        @(posedge clk); #1; rd_n = 1;

        // R8 aliasing across undecoded bits
        bus_write(20'h00044, 1'b0, 16'hA5C3, 1'b1); model_write(20'h00044, 1'b0, 16'hA5C3);
        bus_read(20'hE1044, 1'b0, r); check16(r, 16'hA5C3, "R8 alias upper bits");

        // R9 directed misaligned word
        split_write(20'h00101, 16'hD00D);
        split_read(20'h00101, r); check16(r, 16'hD00D, "R9 split word");
        bus_read(20'h00100, 1'b0, r); check16(r, exp_read(20'h00100, 1'b0), "R9 first row");
        bus_read(20'h00102, 1'b0, r); check16(r, exp_read(20'h00102, 1'b0), "R9 second row");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [15:0] d;
            a = 20'($urandom);
            d = 16'($urandom);
            kind = int'($urandom % 5);
            unique case (kind)
                0: begin a[0] = 0; bus_write(a, 1'b1, d, 1'b1); model_write(a, 1'b1, d);
                       bus_read(a, 1'b1, r); check16(r, exp_read(a, 1'b1), "R1 random even"); end
                1: begin a[0] = 1; bus_write(a, 1'b0, d, 1'b1); model_write(a, 1'b0, d);
                       bus_read(a, 1'b0, r); check16(r, exp_read(a, 1'b0), "R2 random odd"); end
                2: begin a[0] = 0; bus_write(a, 1'b0, d, 1'b1); model_write(a, 1'b0, d);
                       bus_read(a, 1'b0, r); check16(r, exp_read(a, 1'b0), "R3 random word"); end
                3: begin a[0] = 1; split_write(a, d);
                       split_read(a, r); check16(r, d, "R9 random split"); end
                default: begin a[0] = 1; bus_write(a, 1'b1, d, 1'b1);
                       a[0] = 0; bus_read(a, 1'b0, r); check16(r, exp_read(a, 1'b0), "R4 random no-bank"); end
            endcase
        end

        // final sweep against model
        for (int i = 0; i < NBYTE / 2; i++) begin
            bus_read(20'(2 * i), 1'b0, r);
            check16(r, exp_read(20'(2 * i), 1'b0), "R6 sweep");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule